// File: doc/BRIEF.md
# Circular FIFO Controller

This block is the control state machine for a sixteen-entry first-in first-out buffer arranged as a ring. Two wrapping 4-bit positions are kept, one for the slot the next write fills and one for the slot the next read returns. A single equality comparator looks at the two positions. The state machine takes write and read requests and decides whether to serve each one. For each request it serves, it issues a strobe and a step command to the matching position counter.

When the two positions are equal, the buffer is either completely full or completely empty. The comparator cannot tell these two cases apart. The state machine resolves this by holding one of three states: EMPTY, PARTIAL or FULL. It moves to FULL when a lone write makes the positions meet, and to EMPTY when a lone read does. The comparator is fed the post-step counter values, so each state decision uses the positions as they will be after the current cycle's steps.

A small datapath is included so the controller can be exercised as a complete buffer. It contains the storage words with a one-hot write select, the two counters and the comparator. Read data is taken directly from the word at the read position, so it is valid in the same cycle as the read strobe.

Top module: `ring_fifo_ctl`

## Requirements
- R1: While `rst` is high, and on the clock edge that samples it, `empty` goes to 1, `full` goes to 0, and both `wr_ptr` and `rd_ptr` load `RESET_PTR` (default 0).
- R2: A write request made while `full` is 0 raises `wr_stb` in the same cycle. On the next edge, `wr_ptr` advances by one.
- R3: A read request made while `empty` is 0 raises `rd_stb` in the same cycle. On the next edge, `rd_ptr` advances by one.
- R4: A write request made while `full` is 1 produces no `wr_stb`, and `wr_ptr` keeps its value.
- R5: A read request made while `empty` is 1 produces no `rd_stb`, and `rd_ptr` keeps its value.
- R6: Starting from empty, sixteen served writes with no reads raise `full` and clear `empty`. After only fifteen such writes, both flags are 0.
- R7: When a lone served read makes `rd_ptr` equal to `wr_ptr`, `empty` is 1 on the next cycle.
- R8: When both requests arrive with neither flag set, both strobes rise, both counters advance, and `full` and `empty` keep their values.
- R9: When both requests arrive while `empty` is 1, only the write is served. When both arrive while `full` is 1, only the read is served.
- R10: `rd_data` shown together with `rd_stb` equals the words accepted by writes, in the order they were written, across position wrap-around.
- R11: `full` and `empty` are never both 1. The two positions are equal exactly when one of the flags is 1.
- R12: Both positions wrap from 15 to 0 when they advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Write request |
| rd_req | input | 1 | Read request |
| wr_data | input | DATA_W | Word to store when the write is served |
| rd_data | output | DATA_W | Word at the read position |
| wr_stb | output | 1 | Write served this cycle |
| rd_stb | output | 1 | Read served this cycle |
| full | output | 1 | Buffer holds sixteen words |
| empty | output | 1 | Buffer holds no words |
| wr_ptr | output | PTR_W | Position the next write fills |
| rd_ptr | output | PTR_W | Position the next read returns |

## Verification
A write and a read can fall in the same cycle. The bench provokes this in all three states: with the buffer empty, partly filled and full, including partial levels where the positions straddle the 15-to-0 wrap. A reference occupancy count and reference positions predict which strobes must rise. The scoreboard then confirms that the returned word is still the oldest one and that the flags do not move when both operations are served.

// File: rtl/ring_fifo_pkg.sv
package ring_fifo_pkg;

    localparam int PTR_W_DEF  = 4;
    localparam int DATA_W_DEF = 8;

    typedef enum logic [1:0] {
        LVL_EMPTY   = 2'd0,
        LVL_PARTIAL = 2'd1,
        LVL_FULL    = 2'd2
    } level_e;

    typedef struct packed {
        logic wr_stb;
        logic rd_stb;
        logic wr_step;
        logic rd_step;
    } ctl_cmd_t;

    function automatic level_e next_level(
        input level_e cur,
        input logic   wr_go,
        input logic   rd_go,
        input logic   meet_after
    );
        level_e n;
        n = cur;
        if (wr_go && !rd_go) begin
            n = meet_after ? LVL_FULL : LVL_PARTIAL;
        end else if (rd_go && !wr_go) begin
            n = meet_after ? LVL_EMPTY : LVL_PARTIAL;
        end
        return n;
    endfunction

endpackage

// File: rtl/ring_ptr.sv
module ring_ptr #(
    parameter int                 PTR_W     = 4,
    parameter logic [PTR_W-1:0]   RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [PTR_W-1:0] cur,
    output logic [PTR_W-1:0] nxt
);
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    always_comb begin
        nxt = step ? cur + ONE : cur;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= RESET_VAL;
        end else begin
            cur <= nxt;
        end
    end
endmodule

// File: rtl/ptr_match.sv
module ptr_match #(
    parameter int PTR_W = 4
) (
    input  logic [PTR_W-1:0] a,
    input  logic [PTR_W-1:0] b,
    output logic             eq
);
    always_comb begin
        eq = (a == b);
    end
endmodule

// File: rtl/ring_store.sv
module ring_store #(
    parameter int PTR_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << PTR_W;

    logic [DEPTH-1:0]  onehot;
    logic [DATA_W-1:0] words [DEPTH];

    always_comb begin
        onehot = '0;
        onehot[wr_sel] = 1'b1;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (wr_en && onehot[i]) begin
                words[i] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = words[rd_sel];
    end
endmodule

// File: rtl/ring_ctl_fsm.sv
module ring_ctl_fsm
    import ring_fifo_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_req,
    input  logic     rd_req,
    input  logic     meet_after,
    output ctl_cmd_t cmd,
    output level_e   level
);
    logic   wr_go;
    logic   rd_go;
    level_e level_d;

    always_comb begin
        wr_go       = wr_req && (level != LVL_FULL);
        rd_go       = rd_req && (level != LVL_EMPTY);
        cmd.wr_stb  = wr_go;
        cmd.rd_stb  = rd_go;
        cmd.wr_step = wr_go;
        cmd.rd_step = rd_go;
        level_d     = next_level(level, wr_go, rd_go, meet_after);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= LVL_EMPTY;
        end else begin
            level <= level_d;
        end
    end
endmodule

// File: rtl/ring_fifo_ctl.sv
module ring_fifo_ctl
    import ring_fifo_pkg::*;
#(
    parameter int                 PTR_W     = PTR_W_DEF,
    parameter int                 DATA_W    = DATA_W_DEF,
    parameter logic [PTR_W-1:0]   RESET_PTR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_stb,
    output logic              rd_stb,
    output logic              full,
    output logic              empty,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic [PTR_W-1:0]  rd_ptr
);
    ctl_cmd_t         cmd;
    level_e           level;
    logic [PTR_W-1:0] wr_nxt;
    logic [PTR_W-1:0] rd_nxt;
    logic             meet_after;

    ring_ctl_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .wr_req     (wr_req),
        .rd_req     (rd_req),
        .meet_after (meet_after),
        .cmd        (cmd),
        .level      (level)
    );

    ring_ptr #(.PTR_W(PTR_W), .RESET_VAL(RESET_PTR)) u_wptr (
        .clk  (clk),
        .rst  (rst),
        .step (cmd.wr_step),
        .cur  (wr_ptr),
        .nxt  (wr_nxt)
    );

    ring_ptr #(.PTR_W(PTR_W), .RESET_VAL(RESET_PTR)) u_rptr (
        .clk  (clk),
        .rst  (rst),
        .step (cmd.rd_step),
        .cur  (rd_ptr),
        .nxt  (rd_nxt)
    );

    ptr_match #(.PTR_W(PTR_W)) u_match (
        .a  (wr_nxt),
        .b  (rd_nxt),
        .eq (meet_after)
    );

    ring_store #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .wr_en   (cmd.wr_stb),
        .wr_sel  (wr_ptr),
        .wr_data (wr_data),
        .rd_sel  (rd_ptr),
        .rd_data (rd_data)
    );

    always_comb begin
        wr_stb = cmd.wr_stb;
        rd_stb = cmd.rd_stb;
        full   = (level == LVL_FULL);
        empty  = (level == LVL_EMPTY);
    end
endmodule

// File: rtl/ring_fifo_ctl_chk.sv
module ring_fifo_ctl_chk #(
    parameter int PTR_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_req,
    input logic             rd_req,
    input logic             wr_stb,
    input logic             rd_stb,
    input logic             full,
    input logic             empty,
    input logic [PTR_W-1:0] wr_ptr,
    input logic [PTR_W-1:0] rd_ptr
);
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (empty && !full));

    assert_wr_serve_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !full) |-> wr_stb);

    assert_wr_step_R12: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> (wr_ptr == $past(wr_ptr) + ONE));

    assert_rd_serve_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !empty) |-> rd_stb);

    assert_rd_step_R12: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> (rd_ptr == $past(rd_ptr) + ONE));

    assert_no_wr_full_R4: assert property (@(posedge clk) disable iff (rst)
        full |-> !wr_stb);

    assert_wr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(wr_ptr));

    assert_no_rd_empty_R5: assert property (@(posedge clk) disable iff (rst)
        empty |-> !rd_stb);

    assert_rd_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> $stable(rd_ptr));

    assert_both_keep_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && rd_stb) |=> ($stable(full) && $stable(empty)));

    assert_flags_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    assert_meet_flag_R11: assert property (@(posedge clk) disable iff (rst)
        ((wr_ptr == rd_ptr) == (full || empty)));
endmodule

bind ring_fifo_ctl ring_fifo_ctl_chk #(.PTR_W(PTR_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .wr_req (wr_req),
    .rd_req (rd_req),
    .wr_stb (wr_stb),
    .rd_stb (rd_stb),
    .full   (full),
    .empty  (empty),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr)
);

// File: tb/ring_fifo_ctl_test.sv
`timescale 1ns/1ps
module ring_fifo_ctl_test;
    localparam int PTR_W  = 4;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << PTR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_req = 1'b0;
    logic              rd_req = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              wr_stb, rd_stb, full, empty;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [DATA_W-1:0] sb_q[$];
    int               m_cnt = 0;
    logic [PTR_W-1:0] m_wp = '0;
    logic [PTR_W-1:0] m_rp = '0;
    bit               exp_wr = 1'b0;
    bit               exp_rd = 1'b0;
    bit               mon_on = 1'b0;
    logic [DATA_W-1:0] seed_val = 8'h11;

    ring_fifo_ctl #(.PTR_W(PTR_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst(rst), .wr_req(wr_req), .rd_req(rd_req),
        .wr_data(wr_data), .rd_data(rd_data), .wr_stb(wr_stb),
        .rd_stb(rd_stb), .full(full), .empty(empty),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // driver: decides expected service from the reference count, pushes written words
    task automatic drive(input bit w, input bit r);
        @(posedge clk);
        #2;
        wr_req  = w;
        rd_req  = r;
        wr_data = seed_val;
        seed_val = seed_val * 8'd5 + 8'd3;
        exp_wr = w && (m_cnt < DEPTH);
        exp_rd = r && (m_cnt > 0);
        if (exp_wr) sb_q.push_back(wr_data);
    endtask

    // monitor: compares at the falling edge, then advances the reference
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            check(full == (m_cnt == DEPTH), "R6", "full", full, m_cnt == DEPTH);
            check(empty == (m_cnt == 0), "R7", "empty", empty, m_cnt == 0);
            check(!(full && empty), "R11", "flags exclusive", full + empty, 1);
            check(wr_ptr == m_wp, "R12", "wr_ptr", wr_ptr, m_wp);
            check(rd_ptr == m_rp, "R12", "rd_ptr", rd_ptr, m_rp);
            if (wr_req && m_cnt == DEPTH)
                check(wr_stb == 1'b0, "R4", "wr_stb on full", wr_stb, 0);
            else if (rd_req && m_cnt == 0 && wr_req)
                check(wr_stb == exp_wr && rd_stb == 1'b0, "R9", "serve on empty",
                      {wr_stb, rd_stb}, {exp_wr, 1'b0});
            else
                check(wr_stb == exp_wr, "R2", "wr_stb", wr_stb, exp_wr);
            if (rd_req && m_cnt == 0)
                check(rd_stb == 1'b0, "R5", "rd_stb on empty", rd_stb, 0);
            else if (wr_req && rd_req && m_cnt == DEPTH)
                check(rd_stb == 1'b1 && wr_stb == 1'b0, "R9", "serve on full",
                      {wr_stb, rd_stb}, 2'b01);
            else if (wr_req && rd_req)
                check(rd_stb == exp_rd && wr_stb == exp_wr, "R8", "both strobes",
                      {wr_stb, rd_stb}, {exp_wr, exp_rd});
            else
                check(rd_stb == exp_rd, "R3", "rd_stb", rd_stb, exp_rd);
            if (exp_rd && sb_q.size() > 0) begin
                logic [DATA_W-1:0] want;
                want = sb_q.pop_front();
                check(rd_data == want, "R10", "rd_data order", rd_data, want);
            end
            if (exp_wr) m_wp = m_wp + 1'b1;
            if (exp_rd) m_rp = m_rp + 1'b1;
            m_cnt = m_cnt + int'(exp_wr) - int'(exp_rd);
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset values while rst is held
        check(empty == 1'b1 && full == 1'b0, "R1", "reset flags", {full, empty}, 2'b01);
        check(wr_ptr == 0 && rd_ptr == 0, "R1", "reset ptrs", {wr_ptr, rd_ptr}, 0);
        rst = 1'b0;
        mon_on = 1'b1;
        // R5: read on empty
        drive(0, 1);
        drive(0, 1);
        // R9: both on empty
        drive(1, 1);
        drive(0, 1);
        // R6: fill to sixteen
        for (int i = 0; i < DEPTH; i++) drive(1, 0);
        // R4: write on full, R9 both on full
        drive(1, 0);
        drive(1, 1);
        drive(1, 0);
        // R7: drain
        for (int i = 0; i < DEPTH + 2; i++) drive(0, 1);
        // R8 and R12: partial level with both across wrap
        for (int i = 0; i < 5; i++) drive(1, 0);
        for (int i = 0; i < 40; i++) drive(1, 1);
        for (int i = 0; i < 11; i++) drive(1, 0);
        drive(1, 1);
        drive(1, 0);
        for (int i = 0; i < 30; i++) drive(0, 1);
        // mixed traffic
        for (int i = 0; i < 600; i++) begin
            int k;
            k = $urandom_range(0, 9);
            drive(k < 6, k > 3);
        end
        for (int i = 0; i < 40; i++) drive(0, 1);
        drive(0, 0);
        @(posedge clk);
        #2;
        mon_on = 1'b0;
        // R1: synchronous reset after traffic
        wr_req = 1'b0; rd_req = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        #2;
        check(empty == 1'b1 && full == 1'b0, "R1", "re-reset flags", {full, empty}, 2'b01);
        check(wr_ptr == 0 && rd_ptr == 0, "R1", "re-reset ptrs", {wr_ptr, rd_ptr}, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule